// File: doc/BRIEF.md
# Digit-Serial Normal-Basis Square-Multiply Unit

This block multiplies two elements of the binary field GF(2^M) and raises the second operand to a run-time power 2^e during the same pass. The result is C = A × B^(2^e). Elements use a Gaussian normal basis: bit i of every operand and of the result is the coefficient of β^(2^i). In this basis a squaring is a cyclic rotation of the coordinates, so the extra power costs no cycles. The basis type and the bilinear product form are derived at elaboration from M alone.

Both operands are streamed in together, D bits per cycle, from the top digit down. The first digit arrives in the same cycle as the start pulse. After K = ceil(M/D) digits the M-bit product appears on the parallel output, marked by a one-cycle done pulse. The product then holds until the next start or clear. The unit is meant to sit in an inversion or exponentiation loop that alternates plain and square-folded products.

Top module: `nb_sqmul`

## Requirements
- R1: The result equals A × B^(2^e) in the type-T Gaussian normal basis of GF(2^M). Bit i of every element is the coefficient of β^(2^i), and the product is the field product of the underlying Gaussian-period representation.
- R2: The exponent is applied modulo M, so any e in M..2^EW−1 gives the same result as e−M. Raising B to 2^e rotates its coordinates up by e: bit (i+e) mod M of B^(2^e) is bit i of B.
- R3: Each operand is zero-extended to N = K·D bits, with the padding bits above bit M−1 equal to zero. Digit j (j = 0..K−1) carries bits N−1−D·j down to N−D−D·j. Digit 0 is presented with start, and digit j is presented j cycles later. Input bit t of the digit port carries the lower-indexed bit plus t.
- R4: done is high for exactly one cycle, K cycles after the start cycle, which is the cycle after the last digit is captured. It is low in every other cycle.
- R5: Outside an operation, the result holds its value while start and clear stay low, whatever the digit and exponent inputs carry.
- R6: A start that arrives during an operation abandons that operation. The new operation's result is unaffected by the abandoned digits.
- R7: Reset, or a clear pulse, zeroes the result in the following cycle and cancels any operation in flight, so no done follows. Clear wins over a simultaneous start.
- R8: The exponent is sampled only in the start cycle. Its value in later cycles has no effect.
- R9: Elaboration fails for M a multiple of 8 (no such basis exists) and for D outside 1..M.
- R10: If every digit of A is zero, the result at done is zero.
- R11: The all-ones vector is the field unit: A × 1 = A, and 1 × B^(2^e) equals B rotated up by e.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an operation; its cycle carries digit 0 |
| clear | input | 1 | Zeroes the result and aborts any operation |
| e_amt | input | EW | Exponent e of the power 2^e applied to B |
| a_dig | input | D | Current digit of A |
| b_dig | input | D | Current digit of B |
| prod | output | M | Result A × B^(2^e) |
| done | output | 1 | One-cycle pulse when prod becomes valid |

## Verification
Every digit feeds all later cycles through the A and B shadow registers, so a wrong bit in either register corrupts the product seen at done, K cycles after start, for almost every operand pair. An error in the accumulator or in its per-cycle rotation shows up the same way, in the same cycle. A miscounted digit index moves the done pulse, or breaks the zero-product and unit-element cases, at the first operation. Loss of the hold or clear behaviour is visible on prod in the very next idle cycle. An exhaustive sweep over every operand pair and every exponent code of a five-bit field exposes all of these within one operation each.

// File: rtl/nb_sqmul_pkg.sv
package nb_sqmul_pkg;

   localparam int MAX_P = 4096;
   localparam int MAX_T = 64;

   typedef enum logic {ROT_UP = 1'b0, ROT_DOWN = 1'b1} rot_dir_e;

   function automatic int pow_mod(input int b, input int x, input int p);
      int r;
      int bb;
      r  = 1 % p;
      bb = b % p;
      for (int k = 0; k < x; k++) r = (r * bb) % p;
      return r;
   endfunction

   function automatic bit is_prime(input int p);
      if (p < 2) return 1'b0;
      for (int q = 2; q * q <= p; q++)
         if (p % q == 0) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int ord_two(input int p);
      int r;
      r = 2 % p;
      for (int n = 1; n < p; n++) begin
         if (r == 1) return n;
         r = (r * 2) % p;
      end
      return p;
   endfunction

   function automatic int gcd_i(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      for (int n = 0; n < 64 && y != 0; n++) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   // smallest type T with a Gaussian normal basis for GF(2^m), 0 if none
   function automatic int gnb_type(input int m);
      int p;
      int k;
      if (m < 2 || m % 8 == 0) return 0;
      for (int t = 1; t <= MAX_T; t++) begin
         p = t * m + 1;
         if (p <= MAX_P && is_prime(p)) begin
            k = ord_two(p);
            if ((t * m) % k == 0 && gcd_i((t * m) / k, m) == 1) return t;
         end
      end
      return 0;
   endfunction

   // an element of multiplicative order exactly t modulo p
   function automatic int unit_of_order(input int t, input int p);
      bit ok;
      for (int u = 1; u < p; u++) begin
         ok = (pow_mod(u, t, p) == 1);
         for (int s = 1; s < t; s++)
            if (pow_mod(u, s, p) == 1) ok = 1'b0;
         if (ok) return u;
      end
      return 1;
   endfunction

endpackage

// File: rtl/nb_rot_var.sv
module nb_rot_var
   import nb_sqmul_pkg::*;
#(
   parameter int       M   = 11,
   parameter int       SW  = 4,
   parameter rot_dir_e DIR = ROT_UP
)(
   input  logic [M-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [M-1:0]  dout
);

   // stage k rotates by 2^k modulo M, so any amount is taken modulo M
   for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int STEP = (2 ** k) % M;
      logic [M-1:0] s_in;
      logic [M-1:0] s_out;
      if (k == 0) begin : g_first
         assign s_in = din;
      end else begin : g_next
         assign s_in = g_stage[k-1].s_out;
      end
      for (genvar i = 0; i < M; i++) begin : g_bit
         if (DIR == ROT_UP) begin : g_up
            localparam int SRC = (i - STEP + M) % M;
            assign s_out[i] = amt[k] ? s_in[SRC] : s_in[i];
         end else begin : g_dn
            localparam int SRC = (i + STEP) % M;
            assign s_out[i] = amt[k] ? s_in[SRC] : s_in[i];
         end
      end
   end

   assign dout = g_stage[SW-1].s_out;

endmodule

// File: rtl/nb_digit_mul.sv
module nb_digit_mul
   import nb_sqmul_pkg::*;
#(
   parameter int M = 11,
   parameter int D = 3
)(
   input  logic [D-1:0] dig,
   input  logic [M-1:0] vec,
   output logic [M-1:0] prod
);

   localparam int T_TYPE = gnb_type(M);
   localparam int P_LEN  = T_TYPE * M + 1;

   // bilinear form for coordinate 0 of a product: bit (j*M+k) pairs a_j with b_k
   function automatic logic [M*M-1:0] build_form();
      logic [M*M-1:0] f;
      int idx [P_LEN];
      int u;
      int pw;
      int pos;
      f = '0;
      if (T_TYPE == 0) return f;
      for (int k = 0; k < P_LEN; k++) idx[k] = 0;
      u = unit_of_order(T_TYPE, P_LEN);
      for (int i = 0; i < M; i++) begin
         pw = pow_mod(2, i, P_LEN);
         for (int j = 0; j < T_TYPE; j++) begin
            pos = (pw * pow_mod(u, j, P_LEN)) % P_LEN;
            idx[pos] = i;
         end
      end
      for (int k = 1; k < P_LEN; k++) begin
         f[idx[k]*M + idx[P_LEN-k]] = ~f[idx[k]*M + idx[P_LEN-k]];
         if (k != 1)
            f[idx[k]*M + idx[(1-k+P_LEN)%P_LEN]] = ~f[idx[k]*M + idx[(1-k+P_LEN)%P_LEN]];
      end
      return f;
   endfunction

   localparam logic [M*M-1:0] FORM = build_form();

   // coordinate j uses the form on both inputs rotated down by j;
   // the digit only occupies coordinates 0..D-1
   always_comb begin
      logic acc;
      for (int j = 0; j < M; j++) begin
         acc = 1'b0;
         for (int t = 0; t < D; t++)
            for (int q = 0; q < M; q++)
               acc = acc ^ (dig[t] & FORM[((t - j + M) % M) * M + q] & vec[(q + j) % M]);
         prod[j] = acc;
      end
   end

endmodule

// File: rtl/nb_sqmul_ctrl.sv
module nb_sqmul_ctrl #(
   parameter int K  = 4,
   parameter int CW = $clog2(K + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clear,
   output logic act,
   output logic done
);

   logic          busy;
   logic [CW-1:0] cnt;
   logic          last;

   assign act  = !clear && (start || busy);
   assign last = act && (start ? (K == 1) : (cnt == CW'(K - 1)));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (start) begin
            busy <= (K > 1);
            cnt  <= CW'(1);
         end else if (busy) begin
            if (cnt == CW'(K - 1)) busy <= 1'b0;
            cnt <= cnt + CW'(1);
         end
      end
   end

endmodule

// File: rtl/nb_sqmul.sv
module nb_sqmul
   import nb_sqmul_pkg::*;
#(
   parameter int M  = 11,
   parameter int D  = 3,
   parameter int EW = (M > 1) ? $clog2(M) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          clear,
   input  logic [EW-1:0] e_amt,
   input  logic [D-1:0]  a_dig,
   input  logic [D-1:0]  b_dig,
   output logic [M-1:0]  prod,
   output logic          done
);

   localparam int K      = (M + D - 1) / D;
   localparam int T_TYPE = gnb_type(M);

   // R9: configurations without a Gaussian normal basis are refused
   if (M % 8 == 0) begin : g_bad_m
      $error("nb_sqmul: M=%0d is a multiple of 8", M);
   end
   if (D < 1 || D > M) begin : g_bad_d
      $error("nb_sqmul: digit width D=%0d outside 1..M", D);
   end
   if (T_TYPE == 0) begin : g_no_basis
      $error("nb_sqmul: no Gaussian normal basis found for M=%0d", M);
   end

   function automatic logic [M-1:0] frob_d(input logic [M-1:0] v);
      logic [M-1:0] r;
      for (int i = 0; i < M; i++) r[i] = v[(i - D + M) % M];
      return r;
   endfunction

   logic          act;
   logic [M-1:0]  x_q, y_q, z_q;
   logic [M-1:0]  x_c, y_c, z_c;
   logic [M-1:0]  a_vec, b_vec, a_dn, b_up;
   logic [M-1:0]  y_cur, pp_a, pp_b, pp_b_up;
   logic [EW-1:0] e_q, e_use;

   nb_sqmul_ctrl #(.K(K)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .clear (clear),
      .act   (act),
      .done  (done)
   );

   // a start cycle sees empty registers
   assign x_c   = start ? '0 : x_q;
   assign y_c   = start ? '0 : y_q;
   assign z_c   = start ? '0 : z_q;
   assign e_use = start ? e_amt : e_q;
   assign a_vec = M'(a_dig);
   assign b_vec = M'(b_dig);

   // B digit carried into the 2^e frame
   nb_rot_var #(.M(M), .SW(EW), .DIR(ROT_UP)) u_b_place (
      .din (b_vec), .amt (e_use), .dout (b_up)
   );
   // A is kept in the inverse 2^e frame
   nb_rot_var #(.M(M), .SW(EW), .DIR(ROT_DOWN)) u_a_place (
      .din (a_vec), .amt (e_use), .dout (a_dn)
   );

   assign y_cur = frob_d(y_c) ^ b_up;

   nb_digit_mul #(.M(M), .D(D)) u_mul_a (
      .dig (a_dig), .vec (y_cur), .prod (pp_a)
   );
   nb_digit_mul #(.M(M), .D(D)) u_mul_b (
      .dig (b_dig), .vec (x_c), .prod (pp_b)
   );

   nb_rot_var #(.M(M), .SW(EW), .DIR(ROT_UP)) u_pp_rot (
      .din (pp_b), .amt (e_use), .dout (pp_b_up)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         x_q <= '0;
         y_q <= '0;
         z_q <= '0;
         e_q <= '0;
      end else if (act) begin
         x_q <= frob_d(x_c ^ a_dn);
         y_q <= y_cur;
         z_q <= frob_d(z_c) ^ pp_a ^ pp_b_up;
         if (start) e_q <= e_amt;
      end
   end

   assign prod = z_q;

endmodule

// File: rtl/nb_sqmul_chk.sv
module nb_sqmul_chk #(
   parameter int M  = 11,
   parameter int D  = 3,
   parameter int K  = 4,
   parameter int AW = $clog2(K + 2)
)(
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         clear,
   input logic [D-1:0] a_dig,
   input logic [M-1:0] prod,
   input logic         done
);

   logic [AW-1:0] age;
   logic          a_zero;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         age    <= '0;
         a_zero <= 1'b0;
      end else if (start) begin
         age    <= AW'(1);
         a_zero <= (a_dig == '0);
      end else if (age != '0 && age <= AW'(K)) begin
         age <= age + AW'(1);
         if (age < AW'(K)) a_zero <= a_zero && (a_dig == '0);
      end
   end

   assert_done_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done == (age == AW'(K)));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !clear && (age == '0 || age >= AW'(K))) |=> $stable(prod));

   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> (prod == '0 && !done));

   assert_zero_operand_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && a_zero) |-> prod == '0);

endmodule

bind nb_sqmul nb_sqmul_chk #(.M(M), .D(D), .K(K)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .clear (clear),
   .a_dig (a_dig),
   .prod  (prod),
   .done  (done)
);

// File: tb/nb_sqmul_tb_top.sv
module nb_sqmul_tb_top;

   localparam int M  = 5;
   localparam int D  = 2;
   localparam int EW = 3;
   localparam int K  = (M + D - 1) / D;
   localparam int N  = K * D;
   localparam int P  = 2 * M + 1;   // type-2 basis: p = 11, unit of order 2 is p-1

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          clear = 1'b0;
   logic [EW-1:0] e_amt = '0;
   logic [D-1:0]  a_dig = '0;
   logic [D-1:0]  b_dig = '0;
   logic [M-1:0]  prod;
   logic          done;

   int n_chk = 0;
   int n_bad = 0;
   bit reported = 1'b0;
   int idx [P];
   int pw2 [M];

   always #4 clk = ~clk;

   nb_sqmul #(.M(M), .D(D), .EW(EW)) dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .clear (clear),
      .e_amt (e_amt), .a_dig (a_dig), .b_dig (b_dig),
      .prod (prod), .done (done)
   );

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      end
   endtask

   task automatic check(input bit ok, input string req, input logic [M-1:0] got,
                        input logic [M-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   // field product via the Gaussian-period ring GF(2)[x]/(x^P - 1)
   function automatic logic [M-1:0] model_mul(input logic [M-1:0] a, input logic [M-1:0] b);
      logic [P-1:0] ca, cb, cc;
      logic [M-1:0] r;
      ca = '0; cb = '0; cc = '0;
      for (int k = 1; k < P; k++) begin
         ca[k] = a[idx[k]];
         cb[k] = b[idx[k]];
      end
      for (int k = 1; k < P; k++)
         for (int l = 1; l < P; l++)
            if (ca[k] && cb[l]) cc[(k + l) % P] = ~cc[(k + l) % P];
      for (int i = 0; i < M; i++) r[i] = cc[pw2[i]] ^ cc[0];
      return r;
   endfunction

   function automatic logic [M-1:0] rot_up(input logic [M-1:0] v, input int e);
      logic [M-1:0] r;
      for (int i = 0; i < M; i++) r[i] = v[((i - e) % M + M) % M];
      return r;
   endfunction

   // R3: padded vector, top digit first; e only valid in the start cycle (R8)
   task automatic send_digits(input logic [M-1:0] a, input logic [M-1:0] b,
                              input int e, input int n);
      logic [N-1:0] pa, pb;
      pa = N'(a);
      pb = N'(b);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!done) check(1'b1, "R4", '0, '0);
         else check(1'b0, "R4 done during digits", M'(done), '0);
         start = (i == 0);
         e_amt = (i == 0) ? EW'(e) : ~EW'(e);
         a_dig = pa[N-1-D*i -: D];
         b_dig = pb[N-1-D*i -: D];
      end
   endtask

   task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input int e,
                         output logic [M-1:0] got);
      send_digits(a, b, e, K);
      @(negedge clk);
      start = 1'b0;
      a_dig = D'($urandom);
      b_dig = D'($urandom);
      e_amt = EW'($urandom);
      check(done == 1'b1, "R4 done pulse", M'(done), M'(1));
      got = prod;
   endtask

   initial begin
      #(8 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog expired");
      report();
      $finish;
   end

   initial begin
      logic [M-1:0] got, exp, ones, held;
      for (int k = 0; k < P; k++) idx[k] = 0;
      for (int i = 0; i < M; i++) begin
         pw2[i] = (1 << i) % P;
         idx[pw2[i]] = i;
         idx[P - pw2[i]] = i;
      end
      ones = '1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(prod == '0, "R7 reset result", prod, '0);
      check(done == 1'b0, "R7 reset done", M'(done), '0);

      // exhaustive sweep: every A, B and exponent code
      for (int a = 0; a < (1 << M); a++)
         for (int b = 0; b < (1 << M); b++)
            for (int e = 0; e < (1 << EW); e++) begin
               run_op(M'(a), M'(b), e, got);
               exp = model_mul(M'(a), rot_up(M'(b), e));
               check(got == exp, (e >= M) ? "R2 R3 R8" : "R1 R3 R8", got, exp);
               if (a == 0) check(got == '0, "R10", got, '0);
            end

      // unit element
      for (int v = 0; v < (1 << M); v++) begin
         run_op(M'(v), ones, v % (1 << EW), got);
         check(got == M'(v), "R11 A*1", got, M'(v));
         run_op(ones, M'(v), v % M, got);
         check(got == rot_up(M'(v), v % M), "R11 1*B", got, rot_up(M'(v), v % M));
      end

      // idle hold while inputs churn
      run_op(5'h13, 5'h0b, 2, held);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         a_dig = D'($urandom);
         b_dig = D'($urandom);
         e_amt = EW'($urandom);
         check(prod == held, "R5 hold", prod, held);
         check(done == 1'b0, "R5 no done", M'(done), '0);
      end

      // restart mid-operation
      send_digits(5'h1f, 5'h1f, 3, 2);
      run_op(5'h06, 5'h19, 4, got);
      exp = model_mul(5'h06, rot_up(5'h19, 4));
      check(got == exp, "R6 restart", got, exp);

      // clear mid-operation
      send_digits(5'h17, 5'h0d, 1, 2);
      @(negedge clk);
      start = 1'b0;
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      check(prod == '0, "R7 clear result", prod, '0);
      for (int i = 0; i < K + 1; i++) begin
         @(negedge clk);
         check(done == 1'b0, "R7 no done after clear", M'(done), '0);
         check(prod == '0, "R7 stays empty", prod, '0);
      end

      // clear beats start in the same cycle
      run_op(5'h0a, 5'h11, 0, got);
      @(negedge clk);
      start = 1'b1;
      clear = 1'b1;
      @(negedge clk);
      start = 1'b0;
      clear = 1'b0;
      check(prod == '0, "R7 clear priority", prod, '0);
      for (int i = 0; i < K + 1; i++) begin
         @(negedge clk);
         check(done == 1'b0, "R7 no done after clear", M'(done), '0);
      end

      report();
      $finish;
   end

endmodule